// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block answers on a two-wire serial bus as a slave. Behind the bus logic sits a 128-word by 8-bit storage array. The block runs on a fast system clock and oversamples the bus clock (SCL) and data (SDA) lines through a short synchroniser. It detects bus start and stop conditions and recognises a single fixed device address. Over the bus it then serves byte and burst writes and random, current-address and burst reads.

The data line is never driven high. The block has a single enable output, `sda_oe_o`, and raising it pulls the shared line low. The testbench resolves the wired-AND line outside the block and feeds the result back on `sda_i`. A write-protect input stops every change to the array, but the bus protocol runs as usual while it is high. A synchronous active-low reset stands in for power-on reset.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: While reset is low and after it is released, `sda_oe_o` is 0 and the block waits idle for a start condition.
- R2: Bus clocking before any start condition gets no acknowledge, so `sda_oe_o` stays 0 through the ninth clock.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop ends any transfer in progress. Bytes clocked after a stop and before the next start get no acknowledge and change nothing.
- R4: The first byte after a start is the address byte, sent MSB first. Its upper seven bits must equal 1010000. On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R5: The low bit of the address byte selects the direction: 0 is a write and 1 is a read. In a write, the next byte is a word address and only its low 7 bits are used (0x85 selects word 5). Each later data byte is acknowledged, stored at the pointer, and the pointer then increments, wrapping from 127 to 0.
- R6: A random read is a write of the word address, then a repeated start and an address byte with the read bit set. It returns the byte stored at that word address.
- R7: A read starts at the current pointer. The pointer increments after each byte and wraps from 127 to 0. A master NoACK ends the read, and the block then releases SDA until the next start; further clocks read back 0xFF.
- R8: While `wp_i` is 1, data bytes are still acknowledged but the array is not modified. `wp_i` held at 0 allows writes.
- R9: `sda_oe_o` changes only after an SCL falling edge, or on a start or stop. It is therefore stable while SCL is high.
- R10: Data bits move MSB first in both directions, and the received bit count never passes the ninth (acknowledge) clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Resolved bus data line level |
| wp_i | input | 1 | Write protect; 1 blocks array updates |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench uses asymmetric data values (0x12, 0xC5, 0x6B) so that a reversed bit order or a byte taken from the wrong address cannot match. Writes followed by random reads, current-address reads and burst reads show whether the pointer is loaded, kept and incremented correctly. Runs that cross word 127 show the wrap. Address mismatches, clocking with no start, and stops inserted mid-transfer separate correct gating by start and stop from a block that answers any byte it sees. A protected write that is still acknowledged, followed by a read-back of the old value, tells write protection apart from a plain NoACK.

// File: rtl/ee_slv_pkg.sv
// Shared types for the serial memory slave.
package ee_slv_pkg;
    // Transfer phase of the slave controller.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a start, bus ignored
        ST_DEV   = 3'd1,   // receiving the address byte
        ST_WORD  = 3'd2,   // receiving the word address
        ST_WDATA = 3'd3,   // receiving write data bytes
        ST_RDATA = 3'd4    // transmitting read data bytes
    } ee_state_e;
endpackage

// File: rtl/ee_slv_sync.sv
// Synchroniser and bus event detector.
// Brings SCL and SDA into the clk domain through STAGES flops each. It then
// flags SCL edges and start/stop conditions by comparing with the previous
// synchronised level. Assumes the bus is much slower than clk and that both
// lines idle high.
module ee_slv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_d_q;
    logic              sda_d_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop of each line samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe_q[0] <= 1'b1;
                        sda_pipe_q[0] <= 1'b1;
                    end else begin
                        scl_pipe_q[0] <= scl_i;
                        sda_pipe_q[0] <= sda_i;
                    end
                end
            end else begin : g_next
                // Later flops pass the level along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe_q[g] <= 1'b1;
                        sda_pipe_q[g] <= 1'b1;
                    end else begin
                        scl_pipe_q[g] <= scl_pipe_q[g-1];
                        sda_pipe_q[g] <= sda_pipe_q[g-1];
                    end
                end
            end
        end
    endgenerate

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d_q <= 1'b1;
            sda_d_q <= 1'b1;
        end else begin
            scl_d_q <= scl_pipe_q[STAGES-1];
            sda_d_q <= sda_pipe_q[STAGES-1];
        end
    end

    // Decode edges and start/stop from current and previous levels.
    always_comb begin
        scl_s_o    = scl_pipe_q[STAGES-1];
        sda_s_o    = sda_pipe_q[STAGES-1];
        scl_rise_o = scl_s_o & ~scl_d_q;
        scl_fall_o = ~scl_s_o & scl_d_q;
        start_o    = scl_s_o & scl_d_q & sda_d_q & ~sda_s_o;
        stop_o     = scl_s_o & scl_d_q & ~sda_d_q & sda_s_o;
    end

    AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));                                   // R3
    AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> !scl_rise_o && !scl_fall_o);     // R3
endmodule

// File: rtl/ee_slv_mem.sv
// Storage array with a write-protect gate.
// DEPTH words of 8 bits with one write port and an asynchronous read port.
// A write request is dropped whenever wp_i is high. Assumes
// DEPTH == 2**AW. The array has no reset; contents are undefined until
// written.
module ee_slv_mem #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    // Store a byte unless write protect is asserted.
    always_ff @(posedge clk) begin
        if (we_i && !wp_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Read the addressed word without a clock.
    assign rdata_o = mem_q[raddr_i];

    AST_WP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we_i && wp_i) |-> (mem_q[$past(waddr_i)] === $past(mem_q[waddr_i]))); // R8
    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we_i && !wp_i) |-> (mem_q[$past(waddr_i)] === $past(wdata_i)));       // R5
endmodule

// File: rtl/ee_slv_ctrl.sv
// Bus protocol controller for the serial memory slave.
// Follows start/stop, shifts bytes in on SCL rises and out on SCL falls,
// and runs the acknowledge clock. It also keeps the word pointer. All
// outputs are registered. Assumes the edge and condition pulses come from
// ee_slv_sync and last one clk each.
module ee_slv_ctrl
    import ee_slv_pkg::*;
#(
    parameter int          AW       = 7,
    parameter logic [6:0]  DEV_ADDR = 7'b1010000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [7:0]    rdata_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic [AW-1:0] ptr_o,
    output logic          sda_oe_o
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    ee_state_e     state_q;
    logic [3:0]    bit_cnt_q;
    logic          in_ack_q;
    logic [7:0]    shift_q;
    logic [AW-1:0] ptr_q;
    logic          sda_oe_q;
    logic          we_q;
    logic [AW-1:0] waddr_q;
    logic [7:0]    wdata_q;
    logic          receiving;
    logic          byte_full;

    // Receive phases share one shift and acknowledge path.
    always_comb begin
        receiving = (state_q == ST_DEV) || (state_q == ST_WORD) || (state_q == ST_WDATA);
        byte_full = (bit_cnt_q == ACK_SLOT);
    end

    // Main protocol sequencer; start and stop override every phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            in_ack_q  <= 1'b0;
            shift_q   <= '0;
            ptr_q     <= '0;
            sda_oe_q  <= 1'b0;
            we_q      <= 1'b0;
            waddr_q   <= '0;
            wdata_q   <= '0;
        end else begin
            we_q <= 1'b0;
            if (start_i) begin
                state_q   <= ST_DEV;
                bit_cnt_q <= '0;
                in_ack_q  <= 1'b0;
                sda_oe_q  <= 1'b0;
            end else if (stop_i) begin
                state_q   <= ST_IDLE;
                bit_cnt_q <= '0;
                in_ack_q  <= 1'b0;
                sda_oe_q  <= 1'b0;
            end else if (receiving) begin
                if (scl_rise_i && !in_ack_q && !byte_full) begin
                    shift_q   <= {shift_q[6:0], sda_s_i};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else if (scl_fall_i && byte_full && !in_ack_q) begin
                    in_ack_q <= 1'b1;
                    unique case (state_q)
                        ST_DEV: begin
                            if (shift_q[7:1] == DEV_ADDR) begin
                                sda_oe_q <= 1'b1;
                            end else begin
                                state_q   <= ST_IDLE;
                                in_ack_q  <= 1'b0;
                                bit_cnt_q <= '0;
                            end
                        end
                        ST_WORD: begin
                            sda_oe_q <= 1'b1;
                            ptr_q    <= shift_q[AW-1:0];
                        end
                        default: begin
                            sda_oe_q <= 1'b1;
                            we_q     <= 1'b1;
                            waddr_q  <= ptr_q;
                            wdata_q  <= shift_q;
                            ptr_q    <= ptr_q + 1'b1;
                        end
                    endcase
                end else if (scl_fall_i && in_ack_q) begin
                    in_ack_q  <= 1'b0;
                    bit_cnt_q <= '0;
                    sda_oe_q  <= 1'b0;
                    if (state_q == ST_DEV) begin
                        if (shift_q[0]) begin
                            state_q  <= ST_RDATA;
                            shift_q  <= rdata_i;
                            sda_oe_q <= ~rdata_i[7];
                        end else begin
                            state_q <= ST_WORD;
                        end
                    end else if (state_q == ST_WORD) begin
                        state_q <= ST_WDATA;
                    end
                end
            end else if (state_q == ST_RDATA) begin
                if (scl_rise_i && !in_ack_q && !byte_full) begin
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else if (scl_fall_i && !in_ack_q && !byte_full && bit_cnt_q != 4'd0) begin
                    shift_q  <= {shift_q[6:0], 1'b0};
                    sda_oe_q <= ~shift_q[6];
                end else if (scl_fall_i && !in_ack_q && byte_full) begin
                    sda_oe_q <= 1'b0;
                    in_ack_q <= 1'b1;
                    ptr_q    <= ptr_q + 1'b1;
                end else if (scl_rise_i && in_ack_q && sda_s_i) begin
                    state_q   <= ST_IDLE;
                    in_ack_q  <= 1'b0;
                    bit_cnt_q <= '0;
                end else if (scl_fall_i && in_ack_q) begin
                    in_ack_q  <= 1'b0;
                    bit_cnt_q <= '0;
                    shift_q   <= rdata_i;
                    sda_oe_q  <= ~rdata_i[7];
                end
            end
        end
    end

    // Drive the outputs from registers only.
    always_comb begin
        we_o     = we_q;
        waddr_o  = waddr_q;
        wdata_o  = wdata_q;
        ptr_o    = ptr_q;
        sda_oe_o = sda_oe_q;
    end

    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_DEV && bit_cnt_q == 4'd0 && !sda_oe_q));   // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (state_q == ST_IDLE && !sda_oe_q));          // R3
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> $past(scl_fall_i || start_i || stop_i));       // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe_q);                                  // R2
    AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= ACK_SLOT);                                               // R10
    AST_WE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q);                                                      // R5
endmodule

// File: rtl/eeprom_i2c_slave.sv
// Top of the two-wire serial memory slave.
// Connects the bus synchroniser, the protocol controller and the protected
// storage array. The bus data line is open drain: sda_oe_o high pulls it
// low, and the resolved line comes back on sda_i. Reset is synchronous and
// active low.
module eeprom_i2c_slave #(
    parameter int         DEPTH       = 128,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    localparam int AW = $clog2(DEPTH);

    logic          scl_s;
    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_c;
    logic          stop_c;
    logic          we;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata;
    logic [AW-1:0] ptr;
    logic [7:0]    rdata;
    logic          unused_scl;

    assign unused_scl = scl_s;

    ee_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    ee_slv_ctrl #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .rdata_i    (rdata),
        .we_o       (we),
        .waddr_o    (waddr),
        .wdata_o    (wdata),
        .ptr_o      (ptr),
        .sda_oe_o   (sda_oe_o)
    );

    ee_slv_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_i    (wp_i),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (ptr),
        .rdata_o (rdata)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |=> !sda_oe_o);                                   // R1
endmodule

// File: tb/eeprom_i2c_slave_bench.sv
// Scoreboard bench: bus tasks push expected values, a monitor compares observations.
module eeprom_i2c_slave_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_slave u_eeprom_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] obs_q [$];
    int n_checks = 0;
    int n_fail   = 0;
    int glitch   = 0;
    bit done     = 1'b0;

    task automatic expect_item(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic observe(input logic [7:0] v);
        obs_q.push_back(v);
    endtask

    // Monitor: pop one observation and its expectation, then compare.
    always @(negedge clk) begin
        if (obs_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] o;
            logic [7:0] e;
            string t;
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (o !== e) begin
                n_fail++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", t, o, e);
            end
        end
    end

    task automatic bit_io(input logic b, output logic r);
        logic oe_hi;
        sda_m = b;
        repeat (Q) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        oe_hi = sda_oe;
        repeat (Q - 2) @(negedge clk);
        r = sda_line;
        if (sda_oe !== oe_hi) glitch++;
        repeat (Q) @(negedge clk);
        if (sda_oe !== oe_hi) glitch++;
        scl = 1'b0;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        repeat (Q) @(negedge clk);
        scl = 1'b1;
        repeat (Q) @(negedge clk);
        sda_m = 1'b0;
        repeat (Q) @(negedge clk);
        scl = 1'b0;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        repeat (Q) @(negedge clk);
        scl = 1'b1;
        repeat (Q) @(negedge clk);
        sda_m = 1'b1;
        repeat (Q) @(negedge clk);
    endtask

    // Master sends a byte MSB first; checks the slave acknowledge.
    task automatic send(input logic [7:0] d, input logic ack_exp, input string tag);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(d[i], r);
        bit_io(1'b1, r);
        expect_item(tag, {7'd0, ack_exp});
        observe({7'd0, ~r});
    endtask

    // Master reads a byte MSB first and answers ACK or NoACK.
    task automatic recv(input logic mack, input logic [7:0] e, input string tag);
        logic r;
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            d[i] = r;
        end
        bit_io(~mack, r);
        expect_item(tag, e);
        observe(d);
    endtask

    task automatic rd_at(input logic [7:0] a, input logic [7:0] e, input string tag);
        bus_start();
        send(8'hA0, 1'b1, tag);
        send(a, 1'b1, tag);
        bus_start();
        send(8'hA1, 1'b1, tag);
        recv(1'b0, e, tag);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: released while in reset and right after.
        expect_item("R1", 8'd0); observe({7'd0, sda_oe});
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_item("R1", 8'd0); observe({7'd0, sda_oe});

        // R2: clocking with no start gets no acknowledge.
        scl = 1'b0;
        repeat (Q) @(negedge clk);
        send(8'hA0, 1'b0, "R2");

        // R4: wrong address, then silence until the next start.
        bus_start();
        send(8'hA2, 1'b0, "R4");
        send(8'hA0, 1'b0, "R4");
        bus_stop();

        // R5/R10: burst write at word 5 given as 0x85.
        bus_start();
        send(8'hA0, 1'b1, "R4");
        send(8'h85, 1'b1, "R5");
        send(8'h12, 1'b1, "R5");
        send(8'hC5, 1'b1, "R10");
        send(8'h6B, 1'b1, "R5");
        bus_stop();

        // R6/R7: random read then burst, NoACK then released 0xFF.
        bus_start();
        send(8'hA0, 1'b1, "R6");
        send(8'h05, 1'b1, "R6");
        bus_start();
        send(8'hA1, 1'b1, "R6");
        recv(1'b1, 8'h12, "R6");
        recv(1'b1, 8'hC5, "R10");
        recv(1'b0, 8'h6B, "R7");
        recv(1'b0, 8'hFF, "R7");
        bus_stop();

        // R7: current-address read continues from the pointer.
        rd_at(8'h05, 8'h12, "R6");
        bus_start();
        send(8'hA1, 1'b1, "R7");
        recv(1'b0, 8'hC5, "R7");
        bus_stop();

        // R5/R7: write and read across the 127 to 0 wrap.
        bus_start();
        send(8'hA0, 1'b1, "R5");
        send(8'h7F, 1'b1, "R5");
        send(8'h3E, 1'b1, "R5");
        send(8'h9D, 1'b1, "R5");
        bus_stop();
        bus_start();
        send(8'hA0, 1'b1, "R7");
        send(8'h7F, 1'b1, "R7");
        bus_start();
        send(8'hA1, 1'b1, "R7");
        recv(1'b1, 8'h3E, "R7");
        recv(1'b0, 8'h9D, "R7");
        bus_stop();

        // R8: protected write is acknowledged but leaves the old byte.
        wp = 1'b1;
        bus_start();
        send(8'hA0, 1'b1, "R8");
        send(8'h05, 1'b1, "R8");
        send(8'hEE, 1'b1, "R8");
        bus_stop();
        wp = 1'b0;
        rd_at(8'h05, 8'h12, "R8");

        // R3: stop ends the transfer; later bytes are ignored.
        bus_start();
        send(8'hA0, 1'b1, "R3");
        bus_stop();
        scl = 1'b0;
        repeat (Q) @(negedge clk);
        send(8'hA0, 1'b0, "R3");
        bus_start();
        send(8'hA0, 1'b1, "R3");
        send(8'h06, 1'b1, "R3");
        bus_stop();
        scl = 1'b0;
        repeat (Q) @(negedge clk);
        send(8'h77, 1'b0, "R3");
        bus_stop();
        rd_at(8'h06, 8'hC5, "R3");

        // R9: no enable change seen while SCL was high.
        expect_item("R9", 8'd0); observe(glitch[7:0]);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule